// File: doc/BRIEF.md
# Serial Character Receiver with Line-Break Detector

This block turns an asynchronous serial line into characters. It runs on the system clock. An enable pulse at sixteen times the bit rate advances it. In the idle state it waits for the line to drop to space (0). It confirms the start bit half a bit later, then samples each later bit at its centre. A character has 5 to 8 data bits, sent least significant bit first. An optional parity bit and one or two stop bits follow. Each finished character goes to the downstream receive buffer with a one-clock strobe, a parity-error flag and a framing-error flag. A character whose stop bit reads as space is still delivered, with the framing-error flag set. After any character, the receiver stays disarmed until the line has been seen at mark (1) again.

A break detector runs beside the receiver and counts consecutive space samples of the line. It is independent of character framing. When the run reaches a threshold, it sets a sticky break flag, which stays set until the clear input is pulsed. Configuration is expected to stay stable while a character is in flight.

Top module: `uart_brk_rx`

## Requirements
- R1: From idle, the receiver treats a 0 sampled on an enable pulse as a possible start bit and samples the line again on the 8th enable pulse after that. If the line is 1 at that point, the receiver returns to idle and delivers nothing. A space of 8 pulses or fewer is therefore ignored.
- R2: The data length comes from `cfg_bits`: 00=5, 01=6, 10=7, 11=8 bits. Bits arrive least significant first, one every 16 enable pulses after the start-bit centre. `rx_data` holds them right-justified, and its unused upper bits read 0.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. `rx_perr` is 1 when the XOR of the data bits and the parity bit differs from `cfg_par_odd` (0 = even, 1 = odd). When parity is disabled, no parity slot exists and `rx_perr` is 0.
- R4: Each character raises `rx_valid` for exactly one clock. `rx_data`, `rx_perr` and `rx_ferr` hold their values until the next character.
- R5: `cfg_stop` 00 selects one stop bit. Both 01 (one and a half) and 1x select two stop bits, each 16 pulses long. If any stop sample is 0, `rx_ferr` is 1, and the character is still delivered.
- R6: After a character is delivered, no new start bit is accepted until the line has been sampled at 1.
- R7: `brk_flag` sets on the enable pulse that completes a run of 160 (`BRK_RUN`) consecutive 0 samples. A 1 sample restarts the run, so a run of 159 sets nothing. A framing error caused by a shorter run also leaves the flag clear.
- R8: `brk_flag` stays set until `brk_clr` is pulsed. If set and clear happen in the same cycle, set wins. After a clear, the flag does not set again until the line has been sampled at 1 and then completes a new full run.
- R9: Without an enable pulse, neither the receiver outputs nor the break flag change (except when the break flag is cleared).
- R10: After reset, `rx_valid`, `rx_perr`, `rx_ferr` and `brk_flag` are 0, `rx_data` is 0, and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16x bit rate |
| rx_line | input | 1 | Serial line, 1 = mark |
| cfg_bits | input | 2 | Data length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop | input | 2 | Stop-bit code |
| brk_clr | input | 1 | Clears the break flag |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | One-clock character strobe |
| rx_perr | output | 1 | Parity error of last character |
| rx_ferr | output | 1 | Framing error of last character |
| brk_flag | output | 1 | Sticky line-break flag |

## Verification
The assertions check on every cycle the local rules of the block. The strobe is a single clock and occurs only on an enable pulse. The receiver re-arms only after a mark sample. The break flag rises only when the run completes, it clears on request, it is sticky otherwise, and outputs hold between enable pulses. The rules that involve whole characters are shown only by the bench scenarios. These cover bit ordering and data length, parity sense, the treatment of one-and-a-half stop bits as two, rejection of short false starts, and the refusal to restart on a line still held at space. The exact 159/160 boundary of the break run and the long 608-sample space are also bench-only.

// File: rtl/urx_pkg.sv
package urx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_MARK
  } rx_state_e;

  // index of the last data bit for a length code 00..11 -> 5..8 bits
  function automatic logic [2:0] last_bit_idx(input logic [1:0] code);
    return 3'(3'd4 + {1'b0, code});
  endfunction

  // number of stop slots; the one-and-a-half setting takes two full slots
  function automatic logic [1:0] stop_slots(input logic [1:0] code);
    return (code == 2'b00) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic parity_bad(input logic [CHAR_W-1:0] d,
                                      input logic pbit, input logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction
endpackage

// File: rtl/urx_frame.sv
module urx_frame
  import urx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic [1:0]        cfg_bits,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [1:0]        cfg_stop,
  output logic [CHAR_W-1:0] data_o,
  output logic              valid_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              hunting_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [2:0]        bidx;
  logic [CHAR_W-1:0] shreg;
  logic              par_bit;
  logic [1:0]        stops_left;
  logic              ferr_acc;
  logic              slot_end;

  assign slot_end  = tick && (cnt == LAST);
  assign hunting_o = (st == RX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; cnt <= '0; bidx <= '0; shreg <= '0; par_bit <= 1'b0;
      stops_left <= '0; ferr_acc <= 1'b0;
      valid_o <= 1'b0; data_o <= '0; perr_o <= 1'b0; ferr_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_IDLE: if (!line) begin
            st  <= RX_START;
            cnt <= '0;
          end
          RX_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              if (line) st <= RX_IDLE;
              else begin
                st <= RX_DATA; bidx <= '0; shreg <= '0;
              end
            end else cnt <= cnt + 1'b1;
          end
          RX_DATA: begin
            cnt <= cnt + 1'b1;
            if (slot_end) begin
              shreg[bidx] <= line;
              bidx        <= bidx + 1'b1;
              if (bidx == last_bit_idx(cfg_bits)) begin
                st         <= cfg_par_en ? RX_PAR : RX_STOP;
                stops_left <= stop_slots(cfg_stop);
                ferr_acc   <= 1'b0;
              end
            end
          end
          RX_PAR: begin
            cnt <= cnt + 1'b1;
            if (slot_end) begin
              par_bit <= line;
              st      <= RX_STOP;
            end
          end
          RX_STOP: begin
            cnt <= cnt + 1'b1;
            if (slot_end) begin
              ferr_acc <= ferr_acc | !line;
              if (stops_left == 2'd1) begin
                valid_o <= 1'b1;
                data_o  <= shreg;
                perr_o  <= cfg_par_en && parity_bad(shreg, par_bit, cfg_par_odd);
                ferr_o  <= ferr_acc | !line;
                st      <= RX_MARK;
              end else stops_left <= stops_left - 1'b1;
            end
          end
          RX_MARK: if (line) st <= RX_IDLE;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/urx_brk.sv
module urx_brk #(
  parameter int RUN = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic clr,
  output logic hit_o,
  output logic flag_o
);
  localparam int RW = $clog2(RUN + 1);
  localparam logic [RW-1:0] FULL = RW'(RUN);

  logic [RW-1:0] run;

  // the sample that makes the run exactly RUN long
  assign hit_o = tick && !line && (run == FULL - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      flag_o <= 1'b0;
    end else begin
      if (tick) begin
        if (line) run <= '0;
        else if (run != FULL) run <= run + 1'b1;
      end
      if (hit_o)    flag_o <= 1'b1;
      else if (clr) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import urx_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int BRK_RUN = 160
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic        rx_line,
  input  logic [1:0]  cfg_bits,
  input  logic        cfg_par_en,
  input  logic        cfg_par_odd,
  input  logic [1:0]  cfg_stop,
  input  logic        brk_clr,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  output logic        rx_perr,
  output logic        rx_ferr,
  output logic        brk_flag
);
  logic hunting;
  logic brk_hit;

  urx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(rx_line),
    .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .data_o(rx_data), .valid_o(rx_valid),
    .perr_o(rx_perr), .ferr_o(rx_ferr), .hunting_o(hunting)
  );

  urx_brk #(.RUN(BRK_RUN)) u_brk (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(rx_line),
    .clr(brk_clr), .hit_o(brk_hit), .flag_o(brk_flag)
  );
endmodule

// File: rtl/urx_chk.sv
module urx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic       rx_line,
  input logic       brk_clr,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ferr,
  input logic       brk_flag,
  input logic       hunting,
  input logic       brk_hit
);
  assert_valid_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(tick16));

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_rearm_on_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hunting) |-> ($past(rx_line) && $past(tick16)));

  assert_brk_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> $past(brk_hit));

  assert_brk_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_clr && !brk_hit) |=> !brk_flag);

  assert_brk_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !brk_clr) |=> brk_flag);

  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick16 |=> ($stable(rx_data) && $stable(rx_ferr) && !rx_valid));
endmodule

bind uart_brk_rx urx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
  .brk_clr(brk_clr), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_ferr(rx_ferr), .brk_flag(brk_flag), .hunting(hunting), .brk_hit(brk_hit)
);

// File: tb/uart_brk_rx_tb.sv
module uart_brk_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] cfg_bits = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic [1:0] cfg_stop = 2'b00;
  logic       brk_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_perr, rx_ferr, brk_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [9:0] got_q[$];

  uart_brk_rx dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
    .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .brk_clr(brk_clr), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .brk_flag(brk_flag)
  );

  always #5 clk = ~clk;

  // record every delivered character as {perr, ferr, data}
  always @(negedge clk) if (rx_valid) got_q.push_back({rx_perr, rx_ferr, rx_data});

  function automatic logic [7:0] len_mask(input logic [1:0] code);
    return 8'hFF >> (3 - code);
  endfunction

  function automatic int len_of(input logic [1:0] code);
    return 5 + int'(code);
  endfunction

  function automatic logic good_par(input logic [7:0] d, input logic odd);
    logic p = odd;
    for (int i = 0; i < 8; i++) p = p ^ d[i];
    return p;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      rx_line = v; tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pulse_clr();
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input int bad_stop);
    int ns = (cfg_stop == 2'b00) ? 1 : 2;
    hold(1'b0, 16);
    for (int i = 0; i < len_of(cfg_bits); i++) hold(d[i], 16);
    if (cfg_par_en) hold(good_par(d & len_mask(cfg_bits), cfg_par_odd) ^ bad_par, 16);
    for (int s = 1; s <= ns; s++) hold((s == bad_stop) ? 1'b0 : 1'b1, 16);
    hold(1'b1, 32);
  endtask

  task automatic expect_one(input string tag, input logic [7:0] d, input logic pe, input logic fe);
    check({tag, " count"}, got_q.size(), 1);
    if (got_q.size() > 0) check(tag, got_q[0], {pe, fe, d});
    got_q.delete();
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", rx_valid, 0);
    check("R10 flags", {rx_perr, rx_ferr, brk_flag}, 0);
    check("R10 data", rx_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    hold(1'b1, 20);

    // R2 directed: 8-bit and 5-bit, LSB first
    cfg_bits = 2'b11; send(8'hA5, 1'b0, 0); expect_one("R2 8bit", 8'hA5, 0, 0);
    cfg_bits = 2'b00; send(8'hF3, 1'b0, 0); expect_one("R2 5bit", 8'h13, 0, 0);

    // R3 parity even and odd, good and bad
    cfg_bits = 2'b10; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send(8'h35, 1'b1, 0); expect_one("R3 even bad", 8'h35, 1, 0);
    cfg_par_odd = 1'b1;
    send(8'h35, 1'b0, 0); expect_one("R3 odd good", 8'h35, 0, 0);
    cfg_par_en = 1'b0;

    // R5 one-and-a-half acts as two: second slot at space gives framing error
    cfg_bits = 2'b11; cfg_stop = 2'b01;
    send(8'h5A, 1'b0, 2); expect_one("R5 1.5stop slot2", 8'h5A, 0, 1);
    cfg_stop = 2'b00;
    send(8'h81, 1'b0, 1); expect_one("R5 1stop missing", 8'h81, 0, 1);

    // R1 false starts of 4 and 8 pulses
    hold(1'b0, 4); hold(1'b1, 60);
    check("R1 glitch4", got_q.size(), 0);
    hold(1'b0, 8); hold(1'b1, 60);
    check("R1 glitch8", got_q.size(), 0);

    // R6 line kept at space after a framing error; R7 short run
    cfg_bits = 2'b00;
    hold(1'b0, 112); hold(1'b0, 40);
    check("R7 short run no flag", brk_flag, 0);
    hold(1'b1, 16);
    send(8'h15, 1'b0, 0);
    check("R6 count", got_q.size(), 2);
    if (got_q.size() == 2) begin
      check("R6 first", got_q[0], {1'b0, 1'b1, 8'h00});
      check("R6 second", got_q[1], {1'b0, 1'b0, 8'h15});
    end
    got_q.delete();

    // R7 boundary 159 vs 160
    hold(1'b0, 159); hold(1'b1, 40);
    check("R7 159 run", brk_flag, 0);
    hold(1'b0, 160);
    check("R7 160 run", brk_flag, 1);
    hold(1'b1, 40);
    // R9 flag and data hold without enable
    repeat (20) @(negedge clk);
    check("R9 hold", brk_flag, 1);
    pulse_clr();
    check("R8 cleared", brk_flag, 0);

    // R7 long space of 608 samples then mark
    hold(1'b0, 608); hold(1'b1, 16);
    check("R7 608", brk_flag, 1);
    pulse_clr();
    // R8 no re-set while line stays at space
    hold(1'b1, 2); hold(1'b0, 170);
    pulse_clr();
    hold(1'b0, 200);
    check("R8 no reset while low", brk_flag, 0);
    hold(1'b1, 20);
    // R8 set wins over clear
    hold(1'b0, 159);
    rx_line = 1'b0; tick16 = 1'b1; brk_clr = 1'b1;
    @(negedge clk);
    tick16 = 1'b0; brk_clr = 1'b0;
    @(negedge clk);
    check("R8 set wins", brk_flag, 1);
    hold(1'b1, 40);
    pulse_clr();
    got_q.delete();

    // random frames: R2 R3 R4 R5
    for (int k = 0; k < 50; k++) begin
      logic [7:0] d;
      logic bp;
      int bs;
      cfg_bits    = 2'($urandom);
      cfg_par_en  = 1'($urandom);
      cfg_par_odd = 1'($urandom);
      cfg_stop    = 2'($urandom);
      d  = 8'($urandom);
      bp = cfg_par_en & ($urandom_range(0, 3) == 0);
      bs = ($urandom_range(0, 3) == 0) ? $urandom_range(1, (cfg_stop == 2'b00) ? 1 : 2) : 0;
      send(d, bp, bs);
      expect_one("R4 random", d & len_mask(cfg_bits), bp, bs != 0);
      if (brk_flag) pulse_clr();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule